// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a small synchronous static RAM whose data bus can switch between reading and writing on every clock with no idle cycle in between. Every control, address and data input is captured on the rising clock edge. A read delivers its word on the output two enabled edges after the address is captured. A write takes its data from the bus at the same point in the pipeline, so a read and a write issued on neighbouring clocks use the bus in neighbouring cycles.

A load cycle captures a fresh address and a new command. An advance cycle repeats the current command at the next address of a four-word burst. A mode pin selects the burst order: either the count is added to the two low address bits, or it is XORed into them. An active-high freeze input stalls the whole pipeline. The output enable gates a drive flag that stands in for the tri-state data pins.

Top module: `zt_sram`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a rising edge) no read is pending and `rdata_drive` is 0.
- R2: A selected load with `wr_n`=1 places the addressed word on `rdata` after the second enabled edge, counting the edge that captures the address.
- R3: For a selected load with `wr_n`=0, `wdata` is taken at the second enabled edge after the address edge. Only the bytes whose `be_n` bit is 0 are written. Bit i of `be_n` covers `wdata[8i+7:8i]`.
- R4: Reads and writes may alternate on consecutive load cycles with no idle cycle, and each returns or stores the correct data.
- R5: A read of an address whose write has not yet been stored returns the pending write bytes, merged byte by byte with the stored word.
- R6: With `order_ilv`=0, each advance cycle moves the two low address bits to the captured start value plus the count, modulo 4 (start 1 gives 1,2,3,0). The upper address bits are kept.
- R7: With `order_ilv`=1, each advance cycle sets the two low address bits to the start value XOR the count (start 1 gives 1,0,3,2).
- R8: A load cycle is selected only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. Any other combination is a deselect: it writes nothing and drives no read data.
- R9: While `freeze`=1 every other synchronous input is ignored, and all pipeline state and the output word keep their values.
- R10: `rdata_drive` is 1 exactly when `oe_n`=0 and the output stage holds data from a selected read.
- R11: An advance cycle keeps the command type and the select status of the last load. `wr_n` and the chip enables are ignored during an advance, while `be_n` is taken fresh on every enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freeze | input | 1 | 1 stalls the pipeline and ignores the other inputs |
| cs_a_n | input | 1 | Chip enable, active low |
| cs_b | input | 1 | Chip enable, active high |
| cs_c_n | input | 1 | Chip enable, active low |
| adv | input | 1 | 1 advances the burst, 0 loads a new address |
| wr_n | input | 1 | 0 write, 1 read (used on load cycles only) |
| be_n | input | NB | Byte write enables, active low |
| order_ilv | input | 1 | Burst order: 1 XOR order, 0 linear order |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Word address |
| wdata | input | DW | Write data bus |
| rdata | output | DW | Read data word |
| rdata_drive | output | 1 | 1 when rdata is driven onto the bus |

## Verification
A command presented before edge k leaves its read word visible after edge k+1. Its write data must be on the bus before edge k+2. Both counts include only edges with `freeze`=0. The bench drives and samples on falling edges. It moves a two-stage reference pipeline forward only on enabled rising edges, so every comparison is made in the cycle in which the reference says the word is due, however many stalls come in between. Bypass and burst order are checked two enabled edges after the command that causes them, against a word model that stores writes only when their data edge arrives.

// File: rtl/zt_sram_pkg.sv
// Shared types for the zero-turnaround SRAM model.
// Assumes: nothing beyond IEEE 1800-2017.
package zt_sram_pkg;
    // Command carried by a pipeline stage.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } zt_op_e;
endpackage

// File: rtl/zt_burst_addr.sv
// Address register and 2-bit burst counter.
// Captures a new word address on load and steps the counter on advance.
// The two low address bits come from the count, in linear or XOR order.
// Assumes: AW >= 3. The caller qualifies every update with en.
module zt_burst_addr #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          load,
    input  logic          ilv,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_o
);
    localparam int HI = AW - 1;

    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;
    logic [1:0]    low;

    // Capture the start address on load; step the count on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= 2'd0;
        end else if (en) begin
            if (load) begin
                base_q <= addr_in;
                cnt_q  <= 2'd0;
            end else begin
                cnt_q  <= cnt_q + 2'd1;
            end
        end
    end

    // Form the low bits in the selected burst order.
    always_comb begin
        if (ilv) low = base_q[1:0] ^ cnt_q;
        else     low = base_q[1:0] + cnt_q;
    end

    assign addr_o = {base_q[HI:2], low};

    // Linear order: each advance adds one to the low bits (R6).
    p_linear_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && !ilv) |=> (ilv || addr_o[1:0] == $past(addr_o[1:0]) + 2'd1));

    // XOR order: the first advance after a load flips bit 0 only (R7).
    p_ilv_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && load) ##1 (en && !load && ilv) |=> (!ilv || addr_o[1:0] == ($past(addr_o[1:0]) ^ 2'b01)));

    // The upper address bits never move during an advance (R6).
    p_upper_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load) |=> addr_o[HI:2] == $past(addr_o[HI:2]));
endmodule

// File: rtl/zt_cmd_pipe.sv
// Two-stage command pipeline.
// Stage A is the command whose address was captured at the last enabled edge.
// Stage B is the command one edge older; a write in B stores its data at the next enabled edge.
// Assumes: the address of stage A comes from zt_burst_addr. Byte enables are active high here.
module zt_cmd_pipe
    import zt_sram_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          load,
    input  logic          sel,
    input  logic          wr_n,
    input  logic [NB-1:0] be_n,
    input  logic [AW-1:0] a_addr,
    output zt_op_e        a_op,
    output zt_op_e        b_op,
    output logic [AW-1:0] b_addr,
    output logic [NB-1:0] b_be
);
    logic [NB-1:0] a_be;

    // Stage A: a new command on load; an advance keeps the burst's command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_op <= OP_IDLE;
            a_be <= '0;
        end else if (en) begin
            if (load) begin
                if (!sel)      a_op <= OP_IDLE;
                else if (wr_n) a_op <= OP_READ;
                else           a_op <= OP_WRITE;
            end
            a_be <= ~be_n;
        end
    end

    // Stage B: shift stage A down so the write lines up with its data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_op   <= OP_IDLE;
            b_addr <= '0;
            b_be   <= '0;
        end else if (en) begin
            b_op   <= a_op;
            b_addr <= a_addr;
            b_be   <= a_be;
        end
    end

    // An advance never changes the command type (R11).
    p_adv_keeps_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load) |=> a_op == $past(a_op));
endmodule

// File: rtl/zt_store.sv
// Word array, write-to-read bypass and output register.
// Stores the stage-B write with the current wdata on an enabled edge.
// In the same edge, latches the stage-A read word, with the pending bytes merged in.
// Assumes: DW is a multiple of NB. DEPTH is a power of two.
module zt_store
    import zt_sram_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    parameter int NB    = 4,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  zt_op_e        a_op,
    input  logic [AW-1:0] a_addr,
    input  zt_op_e        b_op,
    input  logic [AW-1:0] b_addr,
    input  logic [NB-1:0] b_be,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_q,
    output logic          rd_valid
);
    localparam int BW = DW / NB;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] raw;
    logic [DW-1:0] merged;
    logic          hit;

    assign raw = mem[a_addr];
    assign hit = (b_op == OP_WRITE) && (b_addr == a_addr);

    // One lane per byte: take the pending write byte when it targets this word.
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign merged[g*BW +: BW] = (hit && b_be[g]) ? wdata[g*BW +: BW] : raw[g*BW +: BW];
    end

    // Store the enabled bytes of the stage-B write.
    always_ff @(posedge clk) begin
        if (rst_n && en && b_op == OP_WRITE) begin
            for (int i = 0; i < NB; i++) begin
                if (b_be[i]) mem[b_addr][i*BW +: BW] <= wdata[i*BW +: BW];
            end
        end
    end

    // Output register: load the word of a selected read, keep it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q     <= '0;
            rd_valid <= 1'b0;
        end else if (en) begin
            rd_valid <= (a_op == OP_READ);
            if (a_op == OP_READ) rd_q <= merged;
        end
    end

    // A read with a matching pending write returns the pending bytes (R5).
    p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && a_op == OP_READ && b_op == OP_WRITE && b_addr == a_addr && b_be[0])
        |=> rd_q[BW-1:0] == $past(wdata[BW-1:0]));
endmodule

// File: rtl/zt_sram.sv
// Top of the zero-turnaround pipelined SRAM model.
// Qualifies every pipeline register with the clock enable and decodes the chip selects.
// Drives the read word with a separate drive flag instead of tri-state pins.
// Assumes: order_ilv is held steady while a burst is in flight.
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    parameter int NB    = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          freeze,
    input  logic          cs_a_n,
    input  logic          cs_b,
    input  logic          cs_c_n,
    input  logic          adv,
    input  logic          wr_n,
    input  logic [NB-1:0] be_n,
    input  logic          order_ilv,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rdata_drive
);
    logic          en;
    logic          sel;
    logic [AW-1:0] a_addr;
    logic [AW-1:0] b_addr;
    logic [NB-1:0] b_be;
    zt_op_e        a_op;
    zt_op_e        b_op;
    logic [DW-1:0] rd_q;
    logic          rd_valid;

    // Clock enable and the three-way chip select.
    assign en  = !freeze;
    assign sel = !cs_a_n && cs_b && !cs_c_n;

    zt_burst_addr #(.AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .en(en), .load(!adv),
        .ilv(order_ilv), .addr_in(addr), .addr_o(a_addr)
    );

    zt_cmd_pipe #(.AW(AW), .NB(NB)) u_pipe (
        .clk(clk), .rst_n(rst_n), .en(en), .load(!adv), .sel(sel),
        .wr_n(wr_n), .be_n(be_n), .a_addr(a_addr),
        .a_op(a_op), .b_op(b_op), .b_addr(b_addr), .b_be(b_be)
    );

    zt_store #(.DEPTH(DEPTH), .DW(DW), .NB(NB), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .en(en),
        .a_op(a_op), .a_addr(a_addr), .b_op(b_op), .b_addr(b_addr), .b_be(b_be),
        .wdata(wdata), .rd_q(rd_q), .rd_valid(rd_valid)
    );

    // Output stage: word plus drive flag gated by the output enable.
    assign rdata       = rd_q;
    assign rdata_drive = rd_valid && !oe_n;

    // A selected read load followed by an enabled edge yields valid data (R2).
    p_read_due_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !adv && sel && wr_n) ##1 en |=> rd_valid);

    // A deselect load followed by an enabled edge leaves nothing to drive (R8).
    p_deselect_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !adv && !sel) ##1 en |=> !rd_valid);

    // A stalled edge changes neither the output nor the pipeline (R9).
    p_freeze_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(rd_q) && $stable(rd_valid) && $stable(a_addr) && $stable(b_op) && $stable(a_op)));
endmodule

// File: tb/zt_sram_test.sv
// Self-checking bench for zt_sram: directed corner cases, then seeded random traffic.
// The reference pipeline moves forward only on enabled edges.
module zt_sram_test;
    localparam int  DEPTH  = 64;
    localparam int  DW     = 32;
    localparam int  NB     = 4;
    localparam int  AW     = $clog2(DEPTH);
    localparam int  BW     = DW / NB;
    localparam time PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          freeze = 1'b0;
    logic          cs_a_n = 1'b1;
    logic          cs_b = 1'b0;
    logic          cs_c_n = 1'b1;
    logic          adv = 1'b0;
    logic          wr_n = 1'b1;
    logic [NB-1:0] be_n = '1;
    logic          order_ilv = 1'b0;
    logic          oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_drive;

    int checks = 0;
    int errors = 0;

    // Reference state: op 0 idle, 1 read, 2 write.
    int            m_a_op = 0;
    int            m_b_op = 0;
    logic [AW-1:0] m_b_addr = '0;
    logic [NB-1:0] m_a_be = '0;
    logic [NB-1:0] m_b_be = '0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = 2'd0;
    bit            m_out_valid = 1'b0;
    logic [DW-1:0] m_out = '0;
    logic [DW-1:0] m_mem [DEPTH];

    zt_sram #(.DEPTH(DEPTH), .DW(DW), .NB(NB)) uut (
        .clk(clk), .rst_n(rst_n), .freeze(freeze), .cs_a_n(cs_a_n), .cs_b(cs_b),
        .cs_c_n(cs_c_n), .adv(adv), .wr_n(wr_n), .be_n(be_n), .order_ilv(order_ilv),
        .oe_n(oe_n), .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_drive(rdata_drive)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w, input logic [DW-1:0] new_w,
                                            input logic [NB-1:0] be);
        logic [DW-1:0] r = old_w;
        for (int i = 0; i < NB; i++) if (be[i]) r[i*BW +: BW] = new_w[i*BW +: BW];
        return r;
    endfunction

    function automatic logic [AW-1:0] burst_addr(input logic [AW-1:0] b, input logic [1:0] c, input logic ilv);
        logic [1:0] lo = ilv ? (b[1:0] ^ c) : (b[1:0] + c);
        return {b[AW-1:2], lo};
    endfunction

    // Advance the reference by one rising edge, using the inputs currently driven.
    task automatic model_edge();
        logic [AW-1:0] aa;
        logic [DW-1:0] rd;
        bit            s;
        if (!rst_n) begin
            m_a_op = 0; m_b_op = 0; m_out_valid = 1'b0; m_out = '0;
            m_base = '0; m_cnt = 2'd0; m_a_be = '0; m_b_be = '0; m_b_addr = '0;
        end else if (!freeze) begin
            aa = burst_addr(m_base, m_cnt, order_ilv);
            if (m_a_op == 1) begin
                rd = m_mem[aa];
                if (m_b_op == 2 && m_b_addr == aa) rd = merge(rd, wdata, m_b_be);
                m_out = rd;
                m_out_valid = 1'b1;
            end else begin
                m_out_valid = 1'b0;
            end
            if (m_b_op == 2) m_mem[m_b_addr] = merge(m_mem[m_b_addr], wdata, m_b_be);
            m_b_op = m_a_op; m_b_addr = aa; m_b_be = m_a_be;
            s = !cs_a_n && cs_b && !cs_c_n;
            if (!adv) begin
                m_base = addr; m_cnt = 2'd0;
                m_a_op = !s ? 0 : (wr_n ? 1 : 2);
            end else begin
                m_cnt = m_cnt + 2'd1;
            end
            m_a_be = ~be_n;
        end
    endtask

    task automatic check_out(input string tag);
        bit exp_drive = m_out_valid && !oe_n;
        checks++;
        if (rdata_drive !== exp_drive) begin
            errors++;
            $display("FAIL %s: rdata_drive=%0b expected %0b at %0t", tag, rdata_drive, exp_drive, $time);
        end else if (exp_drive) begin
            checks++;
            if (rdata !== m_out) begin
                errors++;
                $display("FAIL %s: rdata=%h expected %h at %0t", tag, rdata, m_out, $time);
            end
        end
    endtask

    // One cycle: check at the falling edge, drive new inputs, then take the rising edge.
    task automatic step(input bit fz, input bit ad, input bit c0n, input bit c1, input bit c2n,
                        input bit wn, input logic [NB-1:0] ben, input logic [AW-1:0] a,
                        input bit oen, input string tag);
        @(negedge clk);
        check_out(tag);
        freeze = fz; adv = ad; cs_a_n = c0n; cs_b = c1; cs_c_n = c2n;
        wr_n = wn; be_n = ben; addr = a; oe_n = oen; wdata = $urandom;
        @(posedge clk);
        model_edge();
    endtask

    task automatic do_wr(input logic [AW-1:0] a, input logic [NB-1:0] ben, input string tag);
        step(0, 0, 0, 1, 0, 0, ben, a, 0, tag);
    endtask
    task automatic do_rd(input logic [AW-1:0] a, input string tag);
        step(0, 0, 0, 1, 0, 1, '1, a, 0, tag);
    endtask
    task automatic do_nop(input string tag);
        step(0, 0, 1, 1, 0, 1, '1, '0, 0, tag);
    endtask
    task automatic do_adv(input bit wn, input string tag);
        step(0, 1, 1, 0, 1, wn, '1, '0, 0, tag);
    endtask

    initial begin
        void'($urandom(32'd9127));
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        // R1: reset state.
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) do_nop("R1");
        rst_n = 1'b1;
        do_nop("R1");
        do_nop("R1");
        // Fill the array with full-word writes (R3).
        for (int i = 0; i < DEPTH; i++) do_wr(AW'(i), '0, "R3");
        do_nop("R3"); do_nop("R3");
        // R2: plain reads.
        do_rd(6'd4, "R2"); do_rd(6'd7, "R2"); do_nop("R2"); do_nop("R2");
        // R3: partial write, bytes 0 and 2 (be_n = 1010), then read back.
        do_wr(6'd12, 4'b1010, "R3"); do_nop("R3"); do_nop("R3"); do_rd(6'd12, "R3");
        do_nop("R3"); do_nop("R3");
        // R5: read directly after a write to the same word, full and partial.
        do_wr(6'd5, '0, "R5"); do_rd(6'd5, "R5");
        do_wr(6'd6, 4'b0110, "R5"); do_rd(6'd6, "R5"); do_nop("R5"); do_nop("R5");
        // R4: alternating writes and reads with no gap.
        for (int i = 0; i < 8; i++) begin
            if (i % 2 == 0) do_wr(AW'(20 + i), '0, "R4");
            else            do_rd(AW'(19 + i), "R4");
        end
        do_nop("R4"); do_nop("R4");
        // R6: linear burst from start 1 (order 1,2,3,0).
        do_rd(6'd9, "R6"); do_adv(1, "R6"); do_adv(1, "R6"); do_adv(1, "R6");
        do_nop("R6"); do_nop("R6"); do_nop("R6");
        // R7: XOR burst from start 1 (order 1,0,3,2).
        order_ilv = 1'b1;
        do_rd(6'd9, "R7"); do_adv(1, "R7"); do_adv(1, "R7"); do_adv(1, "R7");
        do_nop("R7"); do_nop("R7"); do_nop("R7");
        order_ilv = 1'b0;
        // R7: XOR write burst from start 2, then read the words back.
        order_ilv = 1'b1;
        do_wr(6'd34, '0, "R7"); do_adv(1, "R7"); do_adv(1, "R7"); do_adv(1, "R7");
        do_nop("R7"); do_nop("R7");
        order_ilv = 1'b0;
        for (int i = 32; i < 36; i++) do_rd(AW'(i), "R7");
        do_nop("R7"); do_nop("R7");
        // R11: wr_n low during advance of a read burst is ignored.
        do_rd(6'd40, "R11"); do_adv(0, "R11"); do_adv(0, "R11"); do_nop("R11"); do_nop("R11");
        for (int i = 40; i < 44; i++) do_rd(AW'(i), "R11");
        do_nop("R11"); do_nop("R11");
        // R8: each deselect combination with a write, then read back unchanged.
        step(0, 0, 1, 1, 0, 0, '0, 6'd3, 0, "R8");
        step(0, 0, 0, 0, 0, 0, '0, 6'd3, 0, "R8");
        step(0, 0, 0, 1, 1, 0, '0, 6'd3, 0, "R8");
        step(0, 0, 0, 1, 1, 1, '1, 6'd3, 0, "R8");
        do_nop("R8"); do_nop("R8"); do_rd(6'd3, "R8"); do_nop("R8"); do_nop("R8");
        // R9: stalls inside a read and a write, with junk on the other inputs.
        do_rd(6'd10, "R9");
        step(1, 0, 0, 1, 0, 0, '0, 6'd11, 0, "R9");
        step(1, 1, 0, 1, 0, 0, '0, 6'd12, 0, "R9");
        do_nop("R9");
        step(1, 0, 0, 1, 0, 1, '1, 6'd13, 0, "R9");
        do_wr(6'd14, '0, "R9");
        step(1, 0, 0, 1, 0, 1, '1, 6'd13, 0, "R9");
        do_rd(6'd14, "R9");
        step(1, 0, 1, 0, 1, 0, '0, 6'd1, 0, "R9");
        do_nop("R9"); do_nop("R9"); do_nop("R9");
        // R10: output enable withheld, then given, while a read is held.
        do_rd(6'd2, "R10"); do_nop("R10");
        step(0, 0, 1, 1, 0, 1, '1, '0, 1, "R10");
        step(1, 0, 1, 1, 0, 1, '1, '0, 0, "R10");
        do_nop("R10"); do_nop("R10");
        // Random phase in each burst order.
        for (int ph = 0; ph < 2; ph++) begin
            order_ilv = ph[0];
            for (int n = 0; n < 3000; n++) begin
                step(($urandom % 10) == 0, ($urandom % 10) < 3,
                     ($urandom % 10) == 0, ($urandom % 10) != 0, ($urandom % 10) == 0,
                     $urandom % 2 == 1, NB'($urandom), AW'($urandom), ($urandom % 10) == 0,
                     "R4");
            end
            do_nop("R4"); do_nop("R4"); do_nop("R4");
        end
        do_nop("R2");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, cycles=150000 expected fewer");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule